// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block is a small bus master that performs single read and write accesses to the status and control registers of a line-side PHY device. An internal client presents one request at a time: a direction bit, an 18-bit register address and, for writes, a 32-bit data word. The sequencer then drives active-low chip-enable and output-enable strobes, a read/write line and the address lines through fixed multi-cycle phases, and it moves data on a shared bidirectional data bus.

A write has a set-up cycle with address and direction valid, a chip-enable window in which the write data is driven, and a recovery cycle. A read has a set-up cycle, one cycle of chip enable alone, an output-enable window in which the PHY drives the bus, and a recovery cycle. The word on the bus in the last output-enable cycle is captured and returned with a one-cycle done pulse. Each phase length is a parameter. The block also carries the PHY's active-low interrupt line through a synchronizer to a level status output.

Top module: `phy_reg_seq`

## Requirements
- R1: While reset is asserted and on leaving it: phy_ce_n=1, phy_oe_n=1, phy_rw=0, busy=0, done=0 and irq_pending=0.
- R2: Write (req_write=1). Number the cycle after the accepting clock edge as cycle 1. In cycle 1, phy_rw=0 and phy_addr holds the address while phy_ce_n=1. phy_ce_n is then low for exactly WR_CE_CYC cycles (default 4, cycles 2 to 5), and phy_data carries the write data in each of those cycles. After that, phy_ce_n is high for RECOV_CYC cycles (default 1).
- R3: Read (req_write=0). In cycle 1, phy_rw=1 with the address valid and phy_ce_n=1. phy_ce_n goes low in cycle 2, one cycle before phy_oe_n. phy_oe_n is low for exactly RD_OE_CYC cycles (default 5, cycles 3 to 7). Both strobes rise together and then stay high for RECOV_CYC cycles.
- R4: rdata equals the word on phy_data in the last output-enable cycle. It is valid in the done cycle and is held unchanged until a later read completes, including across writes.
- R5: phy_oe_n is low only in reads, and only while phy_ce_n is low. The block drives phy_data only inside the write chip-enable window.
- R6: busy is 1 from the cycle after acceptance through the done cycle. Requests presented while busy are ignored: the address and strobes of the running access do not change, and no access follows.
- R7: done is a single-cycle pulse. It comes in cycle SETUP+WR_CE+RECOV+1 of a write (cycle 7 by default) and in cycle SETUP+RD_LEAD+RD_OE+RECOV+1 of a read (cycle 9 by default).
- R8: irq_pending is the inverse of phy_irq_n, sampled on rising clock edges through two register stages. A change in the input shows at the output after the second rising edge.
- R9: If req_valid is held high through an access, the next request is accepted on the edge that ends the first idle cycle after done. The cycle after done therefore has busy=0, and the cycle after that has busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | PHY register address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured read data |
| phy_ce_n | output | 1 | PHY chip enable, active low |
| phy_oe_n | output | 1 | PHY output enable, active low |
| phy_rw | output | 1 | 1 = read, 0 = write |
| phy_addr | output | 18 | PHY address lines |
| phy_data | inout | 32 | Shared bidirectional data bus |
| phy_irq_n | input | 1 | PHY interrupt, active low |
| irq_pending | output | 1 | Synchronized interrupt level |

## Verification
Writes and reads are run with distinct addresses and data words, and the strobes are compared cycle by cycle against a timeline. This separates the write window (length 4) from the read window (lead 1, output enable 5) and exposes off-by-one phase lengths. The bench PHY model drives a different word in each output-enable cycle, so a capture made one cycle early or late returns a wrong value. The model's word also differs from any write data, so the block driving the bus during a read shows up as a corrupted result. Further runs cover a request poked in mid-access, a request held high across two accesses, a read followed by a write to test that rdata is held, and interrupt edges in both directions to measure the two-stage latency.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WSTRB,
    ST_RLEAD,
    ST_ROE,
    ST_RECOV,
    ST_DONE
  } seq_state_t;

  // Phase that follows a timed phase once its counter expires.
  function automatic seq_state_t after_phase(input seq_state_t s, input logic is_rd);
    case (s)
      ST_SETUP: return is_rd ? ST_RLEAD : ST_WSTRB;
      ST_WSTRB: return ST_RECOV;
      ST_RLEAD: return ST_ROE;
      ST_ROE:   return ST_RECOV;
      ST_RECOV: return ST_DONE;
      default:  return ST_IDLE;
    endcase
  endfunction

  // Length in cycles of each phase.
  function automatic int unsigned phase_cycles(input seq_state_t s,
                                               input int unsigned setup_c,
                                               input int unsigned wr_c,
                                               input int unsigned lead_c,
                                               input int unsigned oe_c,
                                               input int unsigned recov_c);
    case (s)
      ST_SETUP: return setup_c;
      ST_WSTRB: return wr_c;
      ST_RLEAD: return lead_c;
      ST_ROE:   return oe_c;
      ST_RECOV: return recov_c;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  output logic pending
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= irq_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], irq_n};
      end
    end
  endgenerate

  assign pending = ~chain_q[STAGES-1];
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 32,
  parameter int SETUP_CYC   = 1,
  parameter int WR_CE_CYC   = 4,
  parameter int RD_LEAD_CYC = 1,
  parameter int RD_OE_CYC   = 5,
  parameter int RECOV_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              rw,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              drive_en,
  output logic              accept_evt,
  output logic              capture_evt
);
  localparam int unsigned MAX_LEN = max5(SETUP_CYC, WR_CE_CYC, RD_LEAD_CYC,
                                         RD_OE_CYC, RECOV_CYC);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  seq_state_t        state_q, state_d;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              timed, expired, phase_end, tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  assign timed      = (state_q == ST_SETUP) || (state_q == ST_WSTRB) ||
                      (state_q == ST_RLEAD) || (state_q == ST_ROE) ||
                      (state_q == ST_RECOV);
  assign accept_evt = (state_q == ST_IDLE) && req_valid;
  assign phase_end  = timed && expired;
  assign capture_evt = (state_q == ST_ROE) && expired;

  always_comb begin
    state_d = state_q;
    if (accept_evt)              state_d = ST_SETUP;
    else if (state_q == ST_DONE) state_d = ST_IDLE;
    else if (phase_end)          state_d = after_phase(state_q, rd_q);
  end

  assign tmr_load = accept_evt || phase_end;
  assign tmr_val  = CNT_W'(phase_cycles(state_d, SETUP_CYC, WR_CE_CYC, RD_LEAD_CYC,
                                        RD_OE_CYC, RECOV_CYC) - 1);

  phy_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        rd_q    <= ~req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture_evt) rdata_q <= bus_in;
    end
  end

  assign ce_n     = ~((state_q == ST_WSTRB) || (state_q == ST_RLEAD) || (state_q == ST_ROE));
  assign oe_n     = ~(state_q == ST_ROE);
  assign rw       = (state_q != ST_IDLE) && rd_q;
  assign drive_en = (state_q == ST_WSTRB);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign addr     = addr_q;
  assign wdata    = wdata_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 32,
  parameter int SETUP_CYC   = 1,
  parameter int WR_CE_CYC   = 4,
  parameter int RD_LEAD_CYC = 1,
  parameter int RD_OE_CYC   = 5,
  parameter int RECOV_CYC   = 1,
  parameter int IRQ_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              phy_ce_n,
  output logic              phy_oe_n,
  output logic              phy_rw,
  output logic [ADDR_W-1:0] phy_addr,
  inout  wire  [DATA_W-1:0] phy_data,
  input  logic              phy_irq_n,
  output logic              irq_pending
);
  logic [DATA_W-1:0] bus_in, wdata;
  logic              drive_en, accept_evt, capture_evt;

  assign bus_in   = phy_data;
  assign phy_data = drive_en ? wdata : {DATA_W{1'bz}};

  phy_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .WR_CE_CYC(WR_CE_CYC),
    .RD_LEAD_CYC(RD_LEAD_CYC), .RD_OE_CYC(RD_OE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_in(bus_in),
    .busy(busy), .done(done), .rdata(rdata), .ce_n(phy_ce_n), .oe_n(phy_oe_n),
    .rw(phy_rw), .addr(phy_addr), .wdata(wdata), .drive_en(drive_en),
    .accept_evt(accept_evt), .capture_evt(capture_evt)
  );

  phy_irq_sync #(.STAGES(IRQ_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_n(phy_irq_n), .pending(irq_pending)
  );
endmodule

// File: rtl/phy_reg_seq_chk.sv
module phy_reg_seq_chk #(
  parameter int ADDR_W    = 18,
  parameter int WR_CE_CYC = 4,
  parameter int RD_OE_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              phy_ce_n,
  input logic              phy_oe_n,
  input logic              phy_rw,
  input logic [ADDR_W-1:0] phy_addr,
  input logic              phy_irq_n,
  input logic              irq_pending,
  input logic              accept_evt,
  input logic              capture_evt
);
  int unsigned ce_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run <= 0;
      oe_run <= 0;
    end else begin
      ce_run <= phy_ce_n ? 0 : ce_run + 1;
      oe_run <= phy_oe_n ? 0 : oe_run + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      rst_state_chk: assert (phy_ce_n && phy_oe_n && !phy_rw && !busy && !done && !irq_pending);
    end
  end

  // R2
  wr_ce_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phy_ce_n) && !phy_rw) |-> (ce_run == WR_CE_CYC));

  // R3
  rd_oe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_oe_n) |-> (oe_run == RD_OE_CYC) && phy_ce_n);

  // R3
  rd_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_oe_n) |-> $past(!phy_ce_n));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> $rose(phy_oe_n));

  // R5
  oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_oe_n |-> (!phy_ce_n && phy_rw));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(phy_addr));

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy && phy_ce_n));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!phy_irq_n) && !phy_irq_n) |=> irq_pending);
endmodule

bind phy_reg_seq phy_reg_seq_chk #(
  .ADDR_W(ADDR_W), .WR_CE_CYC(WR_CE_CYC), .RD_OE_CYC(RD_OE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .phy_ce_n(phy_ce_n),
  .phy_oe_n(phy_oe_n), .phy_rw(phy_rw), .phy_addr(phy_addr), .phy_irq_n(phy_irq_n),
  .irq_pending(irq_pending), .accept_evt(accept_evt), .capture_evt(capture_evt)
);

// File: tb/sim_phy_reg_seq.sv
module sim_phy_reg_seq;
  localparam int SETUP = 1, WR_CE = 4, LEAD = 1, RD_OE = 5, RECOV = 1;
  localparam int W_CE_FIRST = SETUP + 1;
  localparam int W_CE_LAST  = SETUP + WR_CE;
  localparam int W_DONE     = W_CE_LAST + RECOV + 1;
  localparam int R_CE_FIRST = SETUP + 1;
  localparam int R_OE_FIRST = SETUP + LEAD + 1;
  localparam int R_OE_LAST  = SETUP + LEAD + RD_OE;
  localparam int R_DONE     = R_OE_LAST + RECOV + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, phy_irq_n = 1'b1;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  wire         busy, done, phy_ce_n, phy_oe_n, phy_rw, irq_pending;
  wire  [31:0] rdata;
  wire  [17:0] phy_addr;
  wire  [31:0] phy_data;

  logic [31:0] model_base = '0;
  int unsigned oe_k = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // PHY model: a distinct word in each output-enable cycle.
  always @(posedge clk) oe_k <= phy_oe_n ? 0 : oe_k + 1;
  assign phy_data = !phy_oe_n ? (model_base ^ oe_k) : 32'hzzzz_zzzz;

  phy_reg_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .phy_ce_n(phy_ce_n), .phy_oe_n(phy_oe_n), .phy_rw(phy_rw),
    .phy_addr(phy_addr), .phy_data(phy_data), .phy_irq_n(phy_irq_n),
    .irq_pending(irq_pending)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_checks(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rq, "idle ce_n", phy_ce_n, 1);
      chk(rq, "idle busy", busy, 0);
      chk(rq, "idle done", done, 0);
    end
  endtask

  task automatic run_access(input bit rd, input logic [17:0] a, input logic [31:0] wd,
                            input logic [31:0] base, input int poke, input bit hold);
    int last;
    string tg;
    bit ece, eoe;
    tg = rd ? "R3" : "R2";
    last = rd ? R_DONE : W_DONE;
    @(negedge clk);
    req_valid = 1; req_write = !rd; req_addr = a; req_wdata = wd; model_base = base;
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      if (c == 1 && !hold) req_valid = 0;
      if (poke != 0 && c == poke) begin
        req_valid = 1; req_write = rd; req_addr = ~a; req_wdata = ~wd;
      end
      if (poke != 0 && c == poke + 1) req_valid = 0;
      ece = rd ? (c >= R_CE_FIRST && c <= R_OE_LAST) : (c >= W_CE_FIRST && c <= W_CE_LAST);
      eoe = rd && (c >= R_OE_FIRST && c <= R_OE_LAST);
      chk(tg, "ce_n", phy_ce_n, !ece);
      chk(rd ? "R3" : "R5", "oe_n", phy_oe_n, !eoe);
      chk(tg, "rw", phy_rw, rd);
      chk(poke != 0 ? "R6" : tg, "addr", phy_addr, a);
      chk("R6", "busy", busy, 1);
      chk("R7", "done", done, c == last);
      if (!rd && ece) chk("R2", "bus wdata", phy_data, wd);
      if (rd && c == last) chk("R4", "rdata", rdata, base ^ (RD_OE - 1));
    end
  endtask

  task automatic test_reset;
    chk("R1", "ce_n", phy_ce_n, 1);
    chk("R1", "oe_n", phy_oe_n, 1);
    chk("R1", "rw", phy_rw, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "irq_pending", irq_pending, 0);
  endtask

  task automatic test_writes;
    run_access(0, 18'h0_0123, 32'hDEAD_BEEF, 32'h0, 0, 0);
    idle_checks(2, "R2");
    run_access(0, 18'h3_FFFF, 32'h0000_0001, 32'h0, 0, 0);
    idle_checks(1, "R2");
  endtask

  task automatic test_reads;
    run_access(1, 18'h1_0A0A, 32'h0, 32'h5A5A_0000, 0, 0);
    idle_checks(2, "R3");
    run_access(1, 18'h0_0001, 32'h0, 32'hC3C3_3C3C, 0, 0);
    // R4: a following write leaves rdata unchanged
    run_access(0, 18'h0_0002, 32'h1111_2222, 32'h0, 0, 0);
    @(negedge clk);
    chk("R4", "rdata held", rdata, 32'hC3C3_3C3C ^ (RD_OE - 1));
  endtask

  task automatic test_ignore_busy;
    run_access(1, 18'h2_4680, 32'h0, 32'h0F0F_0F0F, 4, 0);
    idle_checks(4, "R6");
    run_access(0, 18'h1_1357, 32'hA5A5_A5A5, 32'h0, 3, 0);
    idle_checks(4, "R6");
  endtask

  task automatic test_back_to_back;
    run_access(0, 18'h0_7777, 32'h7777_0000, 32'h0, 0, 1);
    @(negedge clk);
    chk("R9", "busy gap", busy, 0);
    @(negedge clk);
    chk("R9", "busy restart", busy, 1);
    chk("R9", "setup ce_n", phy_ce_n, 1);
    req_valid = 0;
    repeat (W_DONE) @(negedge clk);
    idle_checks(2, "R9");
  endtask

  task automatic test_irq;
    @(negedge clk); phy_irq_n = 0;
    @(negedge clk); chk("R8", "after 1 edge", irq_pending, 0);
    @(negedge clk); chk("R8", "after 2 edges", irq_pending, 1);
    phy_irq_n = 1;
    @(negedge clk); chk("R8", "release 1 edge", irq_pending, 1);
    @(negedge clk); chk("R8", "release 2 edges", irq_pending, 0);
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_writes();
    test_reads();
    test_ignore_busy();
    test_back_to_back();
    test_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog act=hung exp=complete");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule